// File: doc/BRIEF.md
# Shared Interrupt Line Router

The router takes eight level-sensitive shared interrupt requests and one power-management event level and fans them out to 24 global interrupt outputs. Lines 0 to 15 feed a legacy interrupt controller. Lines 16 to 23 feed an advanced interrupt controller. Each request always drives its own dedicated advanced line. It may also drive one legacy line, chosen by a programmable route byte. Several requests can share one legacy line, and that line is the OR of all of them.

The power-management event is merged into one line that a control byte selects. The selection can point to a legacy line or to an advanced line. When software moves the event to a new line while it is asserted, the router first drops the old line for one cycle and only then raises the new line. The controller therefore never sees the event on two lines at once. A query port reports, for any request, the line that an interrupt-routing consumer should use.

Configuration arrives on a simple byte-write port:
- Addresses 0 to 7 are the route bytes for requests 0 to 7.
- Address 8 is the event control byte.

All outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: While reset is asserted and after it is released, every gsi output is 0, every route byte holds 0x80, and the control byte holds 0x00, which selects line 9.
- R2: A route byte uses bit 7 as the legacy-disable flag and bits 4:0 as the legacy line number. Bits 6:5 are stored but have no effect. A write to address k (0 to 7) replaces route byte k.
- R3: Legacy output n (0 to 15) is the OR of every request i whose route byte has bit 7 clear and line number n. A request with bit 7 set drives no legacy line.
- R4: Output 16+i follows request i regardless of its route byte. No other request drives it.
- R5: Bits 2:0 of the control byte select the event line: 0→9, 1→10, 2→11, 4→20, 5→21. Codes 3, 6 and 7 route the event nowhere.
- R6: The event level is ORed into the selected line, on top of any requests that drive that line.
- R7: If the event is high when a control write changes the selected line, the cycle after the write shows neither the old line nor the new line driven by the event. The cycle after that shows the new line.
- R8: The report port gives, one cycle after the request index is presented, the following:
  - if bit 7 is set: enabled, line 16+i;
  - if bit 7 is clear and the line number is 16 or more: disabled, line 0;
  - otherwise: enabled, with the line number from the route byte.
- R9: A change on the request or event inputs appears on gsi_o at the next rising edge. A configuration write appears one edge after the edge that captures it.
- R10: A route with bit 7 clear and line number 16 to 31 drives no legacy line. The request still drives its advanced line.
- R11: Writes to addresses 9 to 15 change neither the outputs nor any reported route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pirq_i | input | 8 | Shared interrupt request levels, index = request number |
| sci_i | input | 1 | Power-management event level |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 4 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| rpt_sel_i | input | 3 | Request index to report a route for |
| gsi_o | output | 24 | Global interrupt outputs |
| rpt_en_o | output | 1 | Reported route is enabled |
| rpt_line_o | output | 5 | Reported route line |

## Verification
The corner cases fall into four groups:
- **Sharing.** Two requests aim at the same legacy line and then release it one at a time. An AND or last-writer merge would drop the line early.
- **Out-of-range routes.** A route with bit 7 clear and a line number of 16 or more must not alias onto a low legacy line. The same route must be reported as disabled rather than as the advanced line.
- **Event selection.** The event is moved between legacy and advanced lines while it is high. A router without the handover pulse would show the event on two lines for a cycle, or skip the gap. The reserved select codes must silence the event completely.
- **Ignored writes.** Writes to unused addresses and a long random mix of requests, event levels and route writes are compared against an independent model on every cycle.

// File: rtl/pirq_rt_pkg.sv
package pirq_rt_pkg;
  localparam int ROUTE_W = 8;
  localparam int DIS_BIT = 7;
  localparam int LINE_W  = 5;

  typedef struct packed {
    logic              valid;
    logic [LINE_W-1:0] line;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [2:0] code);
    sci_tgt_t t;
    t.valid = 1'b1;
    case (code)
      3'd0:    t.line = 5'd9;
      3'd1:    t.line = 5'd10;
      3'd2:    t.line = 5'd11;
      3'd4:    t.line = 5'd20;
      3'd5:    t.line = 5'd21;
      default: begin t.valid = 1'b0; t.line = '0; end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ       = 8,
  parameter int ADDR_W       = 4,
  parameter logic [ROUTE_W-1:0] ROUTE_RST = 8'h80,
  parameter logic [ROUTE_W-1:0] CTRL_RST  = 8'h00
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [ROUTE_W-1:0]               wdata_i,
  input  logic                             sci_i,
  output logic [N_PIRQ-1:0][ROUTE_W-1:0]   route_o,
  output sci_tgt_t                         sci_tgt_o
);
  localparam sci_tgt_t TGT_RST = sci_decode(CTRL_RST[2:0]);

  for (genvar i = 0; i < N_PIRQ; i++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 route_o[i] <= ROUTE_RST;
      else if (we_i && addr_i == ADDR_W'(i))       route_o[i] <= wdata_i;
    end
  end

  logic [ROUTE_W-1:0] ctrl_q;
  logic               hold_q;
  sci_tgt_t           cur_tgt, new_tgt, eff_q;
  logic               ctrl_wr;

  assign ctrl_wr = we_i && addr_i == ADDR_W'(N_PIRQ);
  assign cur_tgt = sci_decode(ctrl_q[2:0]);
  assign new_tgt = sci_decode(wdata_i[2:0]);

  // selection change with SCI high: blank one cycle before the new line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      eff_q  <= TGT_RST;
      hold_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i;
      if (ctrl_wr && new_tgt != cur_tgt) begin
        eff_q  <= sci_i ? '0 : new_tgt;
        hold_q <= sci_i;
      end else if (hold_q) begin
        eff_q  <= cur_tgt;
        hold_q <= 1'b0;
      end
    end
  end

  assign sci_tgt_o = eff_q;
endmodule

// File: rtl/pirq_legacy_or.sv
module pirq_legacy_or
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16
) (
  input  logic [N_PIRQ-1:0]              pirq_i,
  input  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_i,
  input  logic                           sci_i,
  input  sci_tgt_t                       sci_tgt_i,
  output logic [N_LEGACY-1:0]            legacy_o
);
  for (genvar n = 0; n < N_LEGACY; n++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N_PIRQ; i++) begin
        if (pirq_i[i] && !route_i[i][DIS_BIT] &&
            route_i[i][LINE_W-1:0] == LINE_W'(n))
          hit = 1'b1;
      end
      if (sci_i && sci_tgt_i.valid && sci_tgt_i.line == LINE_W'(n))
        hit = 1'b1;
    end
    assign legacy_o[n] = hit;
  end
endmodule

// File: rtl/pirq_apic_or.sv
module pirq_apic_or
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16
) (
  input  logic [N_PIRQ-1:0] pirq_i,
  input  logic              sci_i,
  input  sci_tgt_t          sci_tgt_i,
  output logic [N_PIRQ-1:0] apic_o
);
  for (genvar i = 0; i < N_PIRQ; i++) begin : g_apic
    assign apic_o[i] = pirq_i[i] |
      (sci_i & sci_tgt_i.valid & (sci_tgt_i.line == LINE_W'(N_LEGACY + i)));
  end
endmodule

// File: rtl/pirq_route_report.sv
module pirq_route_report
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16,
  localparam int SEL_W   = $clog2(N_PIRQ)
) (
  input  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_i,
  input  logic [SEL_W-1:0]               sel_i,
  output logic                           en_o,
  output logic [LINE_W-1:0]              line_o
);
  logic [ROUTE_W-1:0] r;
  assign r = route_i[sel_i];

  always_comb begin
    if (r[DIS_BIT]) begin
      en_o   = 1'b1;
      line_o = LINE_W'(N_LEGACY) + LINE_W'(sel_i);
    end else if (r[LINE_W-1:0] >= LINE_W'(N_LEGACY)) begin
      en_o   = 1'b0;
      line_o = '0;
    end else begin
      en_o   = 1'b1;
      line_o = r[LINE_W-1:0];
    end
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_rt_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16,
  parameter int ADDR_W   = 4,
  localparam int N_GSI   = N_LEGACY + N_PIRQ,
  localparam int SEL_W   = $clog2(N_PIRQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PIRQ-1:0]   pirq_i,
  input  logic                sci_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [ROUTE_W-1:0]  cfg_wdata_i,
  input  logic [SEL_W-1:0]    rpt_sel_i,
  output logic [N_GSI-1:0]    gsi_o,
  output logic                rpt_en_o,
  output logic [LINE_W-1:0]   rpt_line_o
);
  logic [N_PIRQ-1:0][ROUTE_W-1:0] route;
  sci_tgt_t                       sci_tgt;
  logic [N_LEGACY-1:0]            legacy_d;
  logic [N_PIRQ-1:0]              apic_d;
  logic                           rpt_en_d;
  logic [LINE_W-1:0]              rpt_line_d;

  pirq_cfg_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .sci_i, .route_o(route), .sci_tgt_o(sci_tgt)
  );

  pirq_legacy_or #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_leg (
    .pirq_i, .route_i(route), .sci_i, .sci_tgt_i(sci_tgt), .legacy_o(legacy_d)
  );

  pirq_apic_or #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_apic (
    .pirq_i, .sci_i, .sci_tgt_i(sci_tgt), .apic_o(apic_d)
  );

  pirq_route_report #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_rpt (
    .route_i(route), .sel_i(rpt_sel_i), .en_o(rpt_en_d), .line_o(rpt_line_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gsi_o      <= '0;
      rpt_en_o   <= 1'b0;
      rpt_line_o <= '0;
    end else begin
      gsi_o      <= {apic_d, legacy_d};
      rpt_en_o   <= rpt_en_d;
      rpt_line_o <= rpt_line_d;
    end
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16,
  localparam int N_GSI   = N_LEGACY + N_PIRQ
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PIRQ-1:0] pirq_i,
  input logic              sci_i,
  input logic [N_GSI-1:0]  gsi_o
);
  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  for (genvar i = 0; i < N_PIRQ; i++) begin : g_follow
    AST_APIC_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_q && $past(pirq_i[i]) |-> gsi_o[N_LEGACY + i]);  // R4
  end

  AST_LEGACY_SOURCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && gsi_o[N_LEGACY-1:0] != '0 |-> $past(pirq_i != '0 || sci_i));  // R3

  AST_SCI_SINGLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && $past(pirq_i) == '0 |-> $countones(gsi_o) <= 1);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && $past(pirq_i) == '0 && !$past(sci_i) |-> gsi_o == '0);  // R9
endmodule

bind pirq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pirq_i(pirq_i), .sci_i(sci_i), .gsi_o(gsi_o)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  localparam int NP = 8;
  localparam int NL = 16;
  localparam int NG = NP + NL;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] pirq;
  logic          sci, we;
  logic [3:0]    addr;
  logic [7:0]    wdata;
  logic [2:0]    rsel;
  wire  [NG-1:0] gsi;
  wire           rpt_en;
  wire  [4:0]    rpt_line;

  pirq_router dut (
    .clk_i(clk), .rst_ni(rst_n), .pirq_i(pirq), .sci_i(sci),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .rpt_sel_i(rsel),
    .gsi_o(gsi), .rpt_en_o(rpt_en), .rpt_line_o(rpt_line)
  );

  typedef struct {
    logic [NG-1:0] gsi;
    logic          en;
    logic [4:0]    line;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   errs = 0;
  int   checks = 0;
  bit   done = 0;

  logic [7:0] m_route [NP];
  logic [7:0] m_ctrl;
  logic       m_eff_v, m_hold;
  logic [4:0] m_eff_l;

  task automatic decode(input logic [2:0] c, output logic v, output logic [4:0] l);
    v = 1'b1;
    case (c)
      3'd0: l = 5'd9;
      3'd1: l = 5'd10;
      3'd2: l = 5'd11;
      3'd4: l = 5'd20;
      3'd5: l = 5'd21;
      default: begin v = 1'b0; l = 5'd0; end
    endcase
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) m_route[i] = 8'h80;
    m_ctrl = 8'h00; m_hold = 1'b0;
    decode(3'd0, m_eff_v, m_eff_l);
  endtask

  task automatic cyc(input logic [NP-1:0] p, input logic s, input logic w,
                     input logic [3:0] a, input logic [7:0] d,
                     input logic [2:0] rs, input string tag);
    exp_t e;
    logic nv, cv;
    logic [4:0] nl, cl;
    @(negedge clk);
    pirq = p; sci = s; we = w; addr = a; wdata = d; rsel = rs;
    e.gsi = '0;
    for (int i = 0; i < NP; i++) begin
      if (p[i]) begin
        e.gsi[NL+i] = 1'b1;
        if (!m_route[i][7] && m_route[i][4:0] < 5'(NL)) e.gsi[m_route[i][4:0]] = 1'b1;
      end
    end
    if (s && m_eff_v) e.gsi[m_eff_l] = 1'b1;
    if (m_route[rs][7]) begin e.en = 1'b1; e.line = 5'(NL) + 5'(rs); end
    else if (m_route[rs][4:0] >= 5'(NL)) begin e.en = 1'b0; e.line = 5'd0; end
    else begin e.en = 1'b1; e.line = m_route[rs][4:0]; end
    e.tag = tag;
    q.push_back(e);
    if (w && a < 4'(NP)) m_route[a[2:0]] = d;
    decode(m_ctrl[2:0], cv, cl);
    decode(d[2:0], nv, nl);
    if (w && a == 4'(NP) && {nv, nl} != {cv, cl}) begin
      m_eff_v = s ? 1'b0 : nv; m_eff_l = s ? 5'd0 : nl; m_hold = s;
    end else if (m_hold) begin
      m_eff_v = cv; m_eff_l = cl; m_hold = 1'b0;
    end
    if (w && a == 4'(NP)) m_ctrl = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc('0, 1'b0, 1'b1, a, d, 3'd0, tag);
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (rst_n && q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (gsi !== e.gsi) begin
        errs++;
        $display("FAIL %s gsi actual=%h expected=%h", e.tag, gsi, e.gsi);
      end
      checks++;
      if (rpt_en !== e.en || rpt_line !== e.line) begin
        errs++;
        $display("FAIL %s report actual=%b/%0d expected=%b/%0d",
                 e.tag, rpt_en, rpt_line, e.en, e.line);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pirq = '0; sci = 1'b0; we = 1'b0; addr = '0; wdata = '0; rsel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (gsi !== '0) begin errs++; $display("FAIL R1 reset gsi actual=%h expected=0", gsi); end
    rst_n = 1'b1;

    // R1 defaults: report for every request is its advanced line
    for (int i = 0; i < NP; i++) cyc('0, 1'b0, 1'b0, 4'd0, 8'd0, 3'(i), "R1 default route");
    // R4: with routes disabled only advanced lines move
    cyc(8'hA5, 1'b0, 1'b0, 4'd0, 8'd0, 3'd2, "R4 apic only");
    cyc(8'h5A, 1'b0, 1'b0, 4'd0, 8'd0, 3'd5, "R4 apic only");
    cyc(8'h00, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0, "R9 release");
    // R2/R3 sharing
    wr(4'd0, 8'h05, "R2 write route0");
    wr(4'd1, 8'h65, "R2 route1 upper bits ignored");
    wr(4'd2, 8'h0A, "R2 write route2");
    cyc(8'h01, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0, "R3 single");
    cyc(8'h03, 1'b0, 1'b0, 4'd0, 8'd0, 3'd1, "R3 shared both");
    cyc(8'h02, 1'b0, 1'b0, 4'd0, 8'd0, 3'd2, "R3 shared one left");
    cyc(8'h06, 1'b0, 1'b0, 4'd0, 8'd0, 3'd2, "R3 two lines");
    cyc(8'h00, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0, "R3 idle");
    // R10 out-of-range legacy number
    wr(4'd3, 8'h14, "R10 route3 to 20");
    wr(4'd4, 8'h10, "R10 route4 to 16");
    cyc(8'h18, 1'b0, 1'b0, 4'd0, 8'd0, 3'd3, "R10 no alias R8 disabled report");
    cyc(8'h18, 1'b0, 1'b0, 4'd0, 8'd0, 3'd4, "R10 R8 report");
    cyc(8'h00, 1'b0, 1'b0, 4'd0, 8'd0, 3'd1, "R8 enabled report");
    // R11 ignored addresses
    wr(4'd9,  8'h03, "R11 addr9");
    wr(4'd12, 8'h01, "R11 addr12");
    wr(4'd15, 8'h02, "R11 addr15");
    for (int i = 0; i < NP; i++) cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'(i), "R11 state intact");
    // R6 SCI on default line 9 shared with request
    wr(4'd5, 8'h09, "R6 route5 to 9");
    cyc(8'h20, 1'b1, 1'b0, 4'd0, 8'd0, 3'd5, "R6 sci and pirq share 9");
    cyc(8'h20, 1'b0, 1'b0, 4'd0, 8'd0, 3'd5, "R6 pirq alone");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd5, "R6 sci alone");
    // R5 every code, SCI low during write
    for (int c = 0; c < 8; c++) begin
      cyc(8'h00, 1'b0, 1'b1, 4'd8, 8'(c), 3'd0, "R5 select");
      cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R5 sci on code");
      cyc(8'h00, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0, "R5 sci off");
    end
    // R7 handover while SCI high: legacy 9 -> 10 -> advanced 20 -> none -> 11
    wr(4'd8, 8'h00, "R7 select 9");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 on 9");
    cyc(8'h00, 1'b1, 1'b1, 4'd8, 8'h01, 3'd0, "R7 write 10");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 gap");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 on 10");
    cyc(8'h00, 1'b1, 1'b1, 4'd8, 8'h04, 3'd0, "R7 write 20");
    cyc(8'h10, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 gap with pirq4");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 on 20");
    cyc(8'h00, 1'b1, 1'b1, 4'd8, 8'h07, 3'd0, "R7 write none");
    cyc(8'h00, 1'b1, 1'b1, 4'd8, 8'h02, 3'd0, "R7 write 11");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 gap 11");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 on 11");
    cyc(8'h00, 1'b1, 1'b1, 4'd8, 8'h02, 3'd0, "R7 same code no gap");
    cyc(8'h00, 1'b1, 1'b0, 4'd0, 8'd0, 3'd0, "R7 still 11");
    // random mix R3 R4 R6 R9
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[7:0], r[8], (r[11:9] == 3'd0), 4'(r[15:12] % 12), r[23:16], r[26:24],
          "R9 random R3 R4 R6");
    end
    cyc(8'h00, 1'b0, 1'b0, 4'd0, 8'd0, 3'd0, "R9 drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule